// File: doc/BRIEF.md
# Ping-Pong ADC Calibration Sequencer

This block schedules two converter channels that both observe the same sensor signal. At any moment one channel, the live channel, converts the sensor input. The other, the idle channel, is first pointed at the ground reference and then at the supply reference, so that its offset and gain can be measured again. After both levels have been taken, the roles change and the other channel is calibrated in the same way. The sensor is therefore sampled without a gap, and each channel's correction keeps following drift.

The sequencer runs a fixed ten-step cycle, five steps for each half, and all of its timing is counted in converter sample strobes. After every change of input source, the new step waits a short settling window and throws those samples away. Each averaging step adds a fixed number of samples from the idle channel. When a calibration level is complete, the block sends a one-cycle pulse to an external coefficient calculator, together with the finished sum. The analog multiplexer, the converter's filter and the correction arithmetic are outside this block.

Top module: `adc_pp_cal`

## Requirements
- R1: After a synchronous reset the block is at step 0: `src_a` = 011 (pin input), `src_b` = 000 (ground), `live_ch` = 0, `acc_active` = 0, `acc_sum` = 0 and `coef_go` = 0.
- R2: The step changes only in the cycle after a clock edge where `smp_stb` is high. Without strobes, every output holds its value.
- R3: A step with a source change or a calculation lasts SETTLE_N strobes. An averaging step lasts AVG_N strobes. `acc_active` is low during the settling steps.
- R4: Source codes are 000 ground, 001 supply and 011 pin input. Within each half, the idle channel goes ground, ground, supply, supply, input over the five steps. The live channel stays on 011.
- R5: `live_ch` (0 = channel A, 1 = channel B) changes only when step 0 (A live) or step 5 (B live) is entered. The live channel's source is always 011.
- R6: `acc_sum` clears to zero on entry to each averaging step. It then adds the raw sample of the idle channel, named by `acc_ch`, on each of the AVG_N strobes. The live channel's raw sample has no effect on the sum.
- R7: `coef_go` is a one-cycle pulse when a calculation step (2, 4, 7, 9) is entered. In that cycle `acc_sum` holds the completed sum, `coef_ch` names the calibrated channel, and `coef_supply` is 0 for the ground level and 1 for the supply level.
- R8: After the last strobe of step 9 the sequence wraps to step 0. Channel A becomes live again, and channel B goes to ground.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe per converter result |
| raw_a | input | DW | Raw result of channel A |
| raw_b | input | DW | Raw result of channel B |
| src_a | output | 3 | Source select for channel A |
| src_b | output | 3 | Source select for channel B |
| live_ch | output | 1 | Channel currently converting the sensor |
| acc_active | output | 1 | High during an averaging step |
| acc_ch | output | 1 | Channel feeding the averager |
| acc_sum | output | DW+log2(AVG_N) | Running sum of calibration samples |
| coef_go | output | 1 | Pulse: calibration level complete |
| coef_supply | output | 1 | Level of the pulse: 0 ground, 1 supply |
| coef_ch | output | 1 | Channel of the pulse |

## Verification
The bench builds the block with its default parameters: 12-bit samples, a settling window of 4 strobes and averaging over 256 strobes. With these values every step boundary is reached, and the settling windows and the last averaging strobe can each be hit by an exact strobe count. The sums run to 20 bits, so the top bits of the accumulator are used. Both halves and the wrap back to the first step are run in full. In every averaging step the live channel carries values unrelated to the idle channel, which shows that they do not reach the sum.

// File: rtl/adc_pp_cal_pkg.sv
package adc_pp_cal_pkg;

  localparam logic [2:0] SRC_GND = 3'b000;
  localparam logic [2:0] SRC_SUP = 3'b001;
  localparam logic [2:0] SRC_IN  = 3'b011;

  localparam int N_STEPS = 10;
  localparam int HALF    = N_STEPS / 2;

  // One step of the calibration cycle
  typedef struct packed {
    logic       wrap;      // last step, return to 0
    logic       live_b;    // channel B converts the sensor
    logic       avg_b;     // channel B feeds the averager
    logic       long_dw;   // averaging dwell instead of settling dwell
    logic       calc;      // coefficient calculation on entry
    logic       lvl_sup;   // averaged level is the supply
    logic [2:0] src_a;
    logic [2:0] src_b;
  } step_t;

  // Step word derived from position: both halves mirror each other
  function automatic step_t step_word(input logic [3:0] idx);
    step_t w;
    int    k;
    logic  h;
    logic [2:0] idle_src;
    h = (int'(idx) >= HALF);
    k = h ? int'(idx) - HALF : int'(idx);
    case (k)
      0, 1:    idle_src = SRC_GND;
      2, 3:    idle_src = SRC_SUP;
      default: idle_src = SRC_IN;
    endcase
    w.wrap    = (int'(idx) == N_STEPS - 1);
    w.live_b  = h;
    w.avg_b   = !h;
    w.long_dw = (k == 1) || (k == 3);
    w.calc    = (k == 2) || (k == 4);
    w.lvl_sup = (k == 4);
    w.src_a   = h ? idle_src : SRC_IN;
    w.src_b   = h ? SRC_IN : idle_src;
    return w;
  endfunction

endpackage

// File: rtl/adc_pp_step_rom.sv
module adc_pp_step_rom
  import adc_pp_cal_pkg::*;
(
  input  logic [3:0] cur_idx,
  input  logic [3:0] nxt_idx,
  output step_t      cur_w,
  output step_t      nxt_w
);
  step_t tbl [N_STEPS];

  for (genvar g = 0; g < N_STEPS; g++) begin : g_tbl
    assign tbl[g] = step_word(4'(g));
  end

  always_comb begin
    cur_w = tbl[0];
    nxt_w = tbl[0];
    for (int i = 0; i < N_STEPS; i++) begin
      if (cur_idx == 4'(i)) cur_w = tbl[i];
      if (nxt_idx == 4'(i)) nxt_w = tbl[i];
    end
  end
endmodule

// File: rtl/adc_pp_dwell.sv
module adc_pp_dwell #(
  parameter int SETTLE_N = 4,
  parameter int AVG_N    = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic long_sel,
  output logic done
);
  localparam int MAXN = (AVG_N > SETTLE_N) ? AVG_N : SETTLE_N;
  localparam int CW   = $clog2(MAXN) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = long_sel ? CW'(AVG_N - 1) : CW'(SETTLE_N - 1);
  assign done = stb && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (done) cnt_q <= '0;
    else if (stb)  cnt_q <= cnt_q + 1'b1;
  end

  // R3: the dwell count never passes the active limit
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last);
endmodule

// File: rtl/adc_pp_accum.sv
module adc_pp_accum #(
  parameter int DW    = 12,
  parameter int AVG_N = 256,
  localparam int SW   = DW + $clog2(AVG_N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          add,
  input  logic [DW-1:0] din,
  output logic [SW-1:0] sum
);
  localparam int NW = $clog2(AVG_N + 1) + 1;
  logic [NW-1:0] n_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sum <= '0;
      n_q <= '0;
    end else if (add) begin
      sum <= sum + SW'(din);
      n_q <= n_q + 1'b1;
    end
  end

  // R6: never more than AVG_N samples since the last clear
  assert_add_count_R6: assert property (@(posedge clk) disable iff (rst)
    n_q <= NW'(AVG_N));
endmodule

// File: rtl/adc_pp_cal.sv
module adc_pp_cal
  import adc_pp_cal_pkg::*;
#(
  parameter int DW       = 12,
  parameter int SETTLE_N = 4,
  parameter int AVG_N    = 256,
  localparam int SW      = DW + $clog2(AVG_N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_stb,
  input  logic [DW-1:0] raw_a,
  input  logic [DW-1:0] raw_b,
  output logic [2:0]    src_a,
  output logic [2:0]    src_b,
  output logic          live_ch,
  output logic          acc_active,
  output logic          acc_ch,
  output logic [SW-1:0] acc_sum,
  output logic          coef_go,
  output logic          coef_supply,
  output logic          coef_ch
);
  logic [3:0] st_q;
  logic [3:0] nxt_idx;
  step_t      cur_w, nxt_w, rst_w;
  logic       adv;

  assign rst_w   = step_word(4'd0);
  assign nxt_idx = cur_w.wrap ? 4'd0 : st_q + 4'd1;

  adc_pp_step_rom u_rom (
    .cur_idx(st_q), .nxt_idx(nxt_idx), .cur_w(cur_w), .nxt_w(nxt_w)
  );

  adc_pp_dwell #(.SETTLE_N(SETTLE_N), .AVG_N(AVG_N)) u_dwell (
    .clk(clk), .rst(rst), .stb(smp_stb), .long_sel(cur_w.long_dw), .done(adv)
  );

  adc_pp_accum #(.DW(DW), .AVG_N(AVG_N)) u_acc (
    .clk(clk), .rst(rst),
    .clr(adv && nxt_w.long_dw),
    .add(smp_stb && cur_w.long_dw),
    .din(cur_w.avg_b ? raw_b : raw_a),
    .sum(acc_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= 4'd0;
      src_a       <= rst_w.src_a;
      src_b       <= rst_w.src_b;
      live_ch     <= rst_w.live_b;
      acc_active  <= 1'b0;
      acc_ch      <= rst_w.avg_b;
      coef_go     <= 1'b0;
      coef_supply <= 1'b0;
      coef_ch     <= 1'b0;
    end else begin
      coef_go <= 1'b0;
      if (adv) begin
        st_q        <= nxt_idx;
        src_a       <= nxt_w.src_a;
        src_b       <= nxt_w.src_b;
        live_ch     <= nxt_w.live_b;
        acc_active  <= nxt_w.long_dw;
        acc_ch      <= nxt_w.avg_b;
        coef_go     <= nxt_w.calc;
        coef_supply <= nxt_w.lvl_sup;
        coef_ch     <= nxt_w.avg_b;
      end
    end
  end

  // R2: step moves only after a strobe
  assert_step_on_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q != $past(st_q)) |-> $past(smp_stb));

  // R5: live channel changes only at the swap steps
  assert_live_swap_R5: assert property (@(posedge clk) disable iff (rst)
    (live_ch != $past(live_ch)) |-> (st_q == 4'd0 || st_q == 4'd5));

  // R5: the live channel is on the pin input
  assert_live_input_R5: assert property (@(posedge clk) disable iff (rst)
    (live_ch ? src_b : src_a) == SRC_IN);

  // R6: the averaged channel is never the live one
  assert_avg_idle_R6: assert property (@(posedge clk) disable iff (rst)
    acc_active |-> (acc_ch != live_ch));

  // R7: coefficient request lasts a single cycle
  assert_coef_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    coef_go |=> !coef_go);
endmodule

// File: tb/adc_pp_cal_test.sv
module adc_pp_cal_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int SETTLE_N = 4;
  localparam int AVG_N = 256;
  localparam int SW = DW + $clog2(AVG_N);

  logic clk = 0;
  logic rst = 1;
  logic smp_stb = 0;
  logic [DW-1:0] raw_a = '0, raw_b = '0;
  logic [2:0] src_a, src_b;
  logic live_ch, acc_active, acc_ch, coef_go, coef_supply, coef_ch;
  logic [SW-1:0] acc_sum;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_pp_cal #(.DW(DW), .SETTLE_N(SETTLE_N), .AVG_N(AVG_N)) uut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .raw_a(raw_a), .raw_b(raw_b),
    .src_a(src_a), .src_b(src_b), .live_ch(live_ch), .acc_active(acc_active),
    .acc_ch(acc_ch), .acc_sum(acc_sum), .coef_go(coef_go),
    .coef_supply(coef_supply), .coef_ch(coef_ch)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic strobe(input logic [DW-1:0] a, input logic [DW-1:0] b);
    @(negedge clk);
    smp_stb = 1; raw_a = a; raw_b = b;
    @(negedge clk);
    smp_stb = 0;
  endtask

  task automatic settle_steps(input int n);
    for (int i = 0; i < n; i++) strobe(12'hFFF, 12'hFFF);
  endtask

  // average idle channel; live channel gets unrelated data (R6)
  task automatic avg_run(input bit idle_b, input int seed, output int sum);
    sum = 0;
    for (int i = 0; i < AVG_N; i++) begin
      int v, w;
      v = (i * 37 + seed) % 4096;
      w = ((i * 91) ^ 12'hA5A) % 4096;
      sum += v;
      if (idle_b) strobe(DW'(w), DW'(v)); else strobe(DW'(v), DW'(w));
      if (i == AVG_N - 2) begin
        check("R3", "no pulse before last avg strobe", int'(coef_go), 0);
        check("R3", "still averaging", int'(acc_active), 1);
      end
    end
  endtask

  task automatic t_reset;
    check("R1", "src_a", int'(src_a), 3);
    check("R1", "src_b", int'(src_b), 0);
    check("R1", "live_ch", int'(live_ch), 0);
    check("R1", "acc_active", int'(acc_active), 0);
    check("R1", "acc_sum", int'(acc_sum), 0);
    check("R1", "coef_go", int'(coef_go), 0);
  endtask

  task automatic t_stall;
    logic [2:0] sa, sb;
    logic lc, aa;
    sa = src_a; sb = src_b; lc = live_ch; aa = acc_active;
    repeat (40) @(negedge clk);
    check("R2", "src_a held", int'(src_a), int'(sa));
    check("R2", "src_b held", int'(src_b), int'(sb));
    check("R2", "live held", int'(live_ch), int'(lc));
    check("R2", "acc_active held", int'(acc_active), int'(aa));
  endtask

  task automatic t_first_half;
    int s;
    settle_steps(SETTLE_N - 1);
    check("R3", "step0 not yet averaging", int'(acc_active), 0);
    settle_steps(1);
    check("R3", "step1 averaging", int'(acc_active), 1);
    check("R6", "acc_ch B", int'(acc_ch), 1);
    check("R6", "sum cleared", int'(acc_sum), 0);
    avg_run(1'b1, 11, s);
    check("R7", "ground pulse", int'(coef_go), 1);
    check("R7", "ground level", int'(coef_supply), 0);
    check("R7", "ground ch", int'(coef_ch), 1);
    check("R6", "ground sum", int'(acc_sum), s);
    check("R4", "src_b supply", int'(src_b), 1);
    @(negedge clk);
    check("R7", "pulse ends", int'(coef_go), 0);
    settle_steps(SETTLE_N);
    check("R6", "sum cleared step3", int'(acc_sum), 0);
    check("R4", "src_b supply step3", int'(src_b), 1);
    avg_run(1'b1, 999, s);
    check("R7", "supply pulse", int'(coef_go), 1);
    check("R7", "supply level", int'(coef_supply), 1);
    check("R6", "supply sum", int'(acc_sum), s);
    check("R4", "src_b input", int'(src_b), 3);
    check("R5", "A still live", int'(live_ch), 0);
  endtask

  task automatic t_swap_second_half;
    int s;
    settle_steps(SETTLE_N - 1);
    check("R5", "no early swap", int'(live_ch), 0);
    settle_steps(1);
    check("R5", "B live", int'(live_ch), 1);
    check("R4", "src_a ground", int'(src_a), 0);
    check("R4", "src_b input", int'(src_b), 3);
    settle_steps(SETTLE_N);
    check("R6", "acc_ch A", int'(acc_ch), 0);
    avg_run(1'b0, 2047, s);
    check("R7", "A ground pulse", int'(coef_go), 1);
    check("R7", "A ground ch", int'(coef_ch), 0);
    check("R6", "A ground sum", int'(acc_sum), s);
    check("R4", "src_a supply", int'(src_a), 1);
    settle_steps(SETTLE_N);
    avg_run(1'b0, 4000, s);
    check("R7", "A supply level", int'(coef_supply), 1);
    check("R6", "A supply sum", int'(acc_sum), s);
    check("R4", "src_a input", int'(src_a), 3);
    check("R5", "B live at step9", int'(live_ch), 1);
  endtask

  task automatic t_wrap;
    settle_steps(SETTLE_N);
    check("R8", "A live after wrap", int'(live_ch), 0);
    check("R8", "src_b ground", int'(src_b), 0);
    check("R8", "src_a input", int'(src_a), 3);
    check("R8", "not averaging", int'(acc_active), 0);
    settle_steps(SETTLE_N);
    check("R8", "averaging B again", int'(acc_active), 1);
    check("R8", "acc_ch B", int'(acc_ch), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_stall();
    t_first_half();
    t_stall();
    t_swap_second_half();
    t_wrap();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule